// File: doc/BRIEF.md
# Interval Carry Flag Unit

This block gives a small controller a periodic time base that software polls. A free-running prescaler produces a square-wave set pulse whose period is picked by a two-bit mode input. Each rising edge of that pulse sets a sticky carry flag. Software reads the flag as bit 0 of a status register. The read returns the flag and clears it in the same access, so a program that polls the register sees exactly one `1` per elapsed interval.

After a power-on reset the flag is disarmed. Set pulses are ignored until software has read the status register once, so that first read always returns 0. A low-to-high transition on the chip-enable pin is synchronized and held as a pending request. The chip-enable reset pulse is then issued in the cycle of the next carry set event. Software that reads the flag right after a reset can therefore tell a cold power-up from a chip-enable restart. Writes on the bus never change the flag.

Top module: `carry_tick_unit`

## Requirements
- R1: With mode code m (0 to 3), the period is P = 2^(4+2m) clocks. Counting from a restart edge, the flag is set on edges P/2+1, then every P after that. A restart edge is the second rising edge after `rst_n` rises, or the edge that first samples a new `mode_sel` value.
- R2: A read strobe at address 0 returns the flag in bit 0 of `bus_rdata` during that cycle, and the flag is 0 after that edge.
- R3: Once set, the flag stays 1 across any number of further set events until it is read.
- R4: During reset `bus_rdata` and `ce_reset_o` are 0. After reset, set events are ignored until the first read at address 0, and that first read returns 0.
- R5: Bits 7 to 1 of a status read are 0. A read strobe at any address other than 0 returns 0 and leaves the flag unchanged.
- R6: Write strobes at any address, with any data, leave the flag unchanged.
- R7: `ce_pin` passes through two synchronizer flops, and a rise seen on the synchronized level arms a pending request on the edge after. `ce_reset_o` is high in the cycle just before the first flag-setting edge that follows the arming. This holds whether or not the flag is armed.
- R8: `ce_reset_o` is high for exactly one cycle per pin rise. It does not disarm the flag.
- R9: When a set event and a status read share a cycle, the read returns the old value and the flag ends at 1.
- R10: A change of `mode_sel` restarts the prescaler count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ce_pin | input | 1 | Asynchronous chip-enable pin |
| mode_sel | input | 2 | Interval select code m |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address; status is at 0 |
| bus_wdata | input | 8 | Write data (has no effect) |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| ce_reset_o | output | 1 | One-cycle chip-enable reset pulse |

## Verification
The bench first polls before the first read, where a design that failed to disarm would return 1 on the very first access. It then lines up a read exactly on a set event. A design that let the clear win would lose that carry, and a later read would return 0 instead of 1. A chip-enable rise is issued both before and after arming, and mode is switched mid-count. An early, late or repeated `ce_reset_o`, or a prescaler that is not restarted, shows up either as a pulse-by-pulse mismatch against a cycle-exact reference model or as a wrong read value.

// File: rtl/ctu_pkg.sv
`timescale 1ns/1ps
package ctu_pkg;
  localparam int MODE_W      = 2;
  localparam int BASE_LOG    = 4;
  localparam int STEP_LOG    = 2;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 8;
  localparam int STATUS_ADDR = 0;
  localparam int SYNC_STAGES = 2;
  localparam int RST_STAGES  = 2;
endpackage

// File: rtl/ctu_prescaler.sv
`timescale 1ns/1ps
module ctu_prescaler #(
  parameter int MODE_W   = 2,
  parameter int BASE_LOG = 4,
  parameter int STEP_LOG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  output logic              set_evt_o
);
  localparam int NUM_MODES = 1 << MODE_W;
  localparam int CNT_W     = BASE_LOG + STEP_LOG * (NUM_MODES - 1);

  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [MODE_W-1:0]    mode_q, mode_d;
  logic                 pulse_q, pulse_d;
  logic [NUM_MODES-1:0] taps;
  logic                 pulse;
  logic                 restart;

  // one square-wave tap per selectable interval
  for (genvar g = 0; g < NUM_MODES; g++) begin : g_tap
    assign taps[g] = cnt_q[BASE_LOG - 1 + STEP_LOG * g];
  end

  assign pulse     = taps[mode_q];
  assign restart   = (mode_i != mode_q);
  assign set_evt_o = pulse & ~pulse_q;

  always_comb begin
    cnt_d   = restart ? '0 : cnt_q + 1'b1;
    mode_d  = mode_i;
    pulse_d = pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mode_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      pulse_q <= pulse_d;
    end
  end
endmodule

// File: rtl/ctu_ce_sync.sv
`timescale 1ns/1ps
module ctu_ce_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q, last_d;

  always_comb begin
    chain_d[0] = pin_i;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    last_d = chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end
endmodule

// File: rtl/ctu_carry_flag.sv
`timescale 1ns/1ps
module ctu_carry_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt_i,
  input  logic clr_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic set_ok;

  assign set_ok = set_evt_i & armed_q;

  always_comb begin
    armed_d = armed_q | clr_i;
    if (set_ok)     flag_d = 1'b1;   // a set wins over a same-cycle clear
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/carry_tick_unit.sv
`timescale 1ns/1ps
module carry_tick_unit
  import ctu_pkg::*;
#(
  parameter int P_MODE_W = MODE_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_pin,
  input  logic [P_MODE_W-1:0] mode_sel,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [P_ADDR_W-1:0] bus_addr,
  input  logic [P_DATA_W-1:0] bus_wdata,
  output logic [P_DATA_W-1:0] bus_rdata,
  output logic                ce_reset_o
);
  localparam logic [P_ADDR_W-1:0] STAT_A = P_ADDR_W'(STATUS_ADDR);

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;
  logic                  set_evt;
  logic                  ce_rise;
  logic                  rd_hit;
  logic                  flag;
  logic                  armed;
  logic                  pend_q, pend_d;
  logic                  wr_unused;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  ctu_prescaler #(
    .MODE_W  (P_MODE_W),
    .BASE_LOG(BASE_LOG),
    .STEP_LOG(STEP_LOG)
  ) u_presc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mode_i   (mode_sel),
    .set_evt_o(set_evt)
  );

  ctu_ce_sync #(.STAGES(SYNC_STAGES)) u_cesync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pin_i (ce_pin),
    .rise_o(ce_rise)
  );

  assign rd_hit = bus_rd & (bus_addr == STAT_A);

  ctu_carry_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_evt_i(set_evt),
    .clr_i    (rd_hit),
    .flag_o   (flag),
    .armed_o  (armed)
  );

  // writes are decoded nowhere: the status bit is read-only
  assign wr_unused = bus_wr ^ (^bus_wdata);

  always_comb begin
    pend_d = ce_rise | (pend_q & ~set_evt);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pend_q <= 1'b0;
    else             pend_q <= pend_d;
  end

  assign ce_reset_o = pend_q & set_evt;
  assign bus_rdata  = rd_hit ? {{(P_DATA_W-1){1'b0}}, flag} : '0;
endmodule

// File: rtl/ctu_checker.sv
`timescale 1ns/1ps
module ctu_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          set_evt,
  input logic          rd_hit,
  input logic          bus_wr,
  input logic          flag,
  input logic          armed,
  input logic [DW-1:0] bus_rdata,
  input logic          ce_reset_o
);
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && armed) |=> flag);  // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !set_evt) |=> !flag);  // R2
  AST_DISARMED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !flag);  // R4
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:1] == '0);  // R5
  AST_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !rd_hit && !set_evt) |=> $stable(flag));  // R6
  AST_CE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_reset_o |-> set_evt);  // R7
  AST_CE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ce_reset_o |=> !ce_reset_o);  // R8
  AST_CE_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_reset_o && armed) |=> (armed && flag));  // R8
  AST_TIE_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && rd_hit && armed) |=> flag);  // R9
endmodule

bind carry_tick_unit ctu_checker #(.DW(P_DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .set_evt   (set_evt),
  .rd_hit    (rd_hit),
  .bus_wr    (bus_wr),
  .flag      (flag),
  .armed     (armed),
  .bus_rdata (bus_rdata),
  .ce_reset_o(ce_reset_o)
);

// File: tb/carry_tick_unit_test.sv
`timescale 1ns/1ps
module carry_tick_unit_test;
  logic       clk;
  logic       rst_n;
  logic       ce_pin;
  logic [1:0] mode_sel;
  logic       bus_rd;
  logic       bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       ce_reset_o;

  carry_tick_unit uut (
    .clk(clk), .rst_n(rst_n), .ce_pin(ce_pin), .mode_sel(mode_sel),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ce_reset_o(ce_reset_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int ce_seen = 0;

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t sb_q[$];

  // reference model, written from the requirements
  int m_hold, m_cnt, m_mode;
  bit m_en, m_flag, m_s1, m_s2, m_s3, m_pend;
  bit u_e, u_rd, u_rise;

  function automatic int per(input int md);
    return 1 << (4 + 2 * md);
  endfunction

  function automatic bit evt_now();
    return (m_hold >= 2) && ((m_cnt % per(m_mode)) == per(m_mode) / 2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 0; m_cnt = 0; m_mode = 0;
      m_en = 0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pend = 0;
    end else if (m_hold < 2) begin
      m_hold++;
    end else begin
      u_e    = evt_now();
      u_rd   = bus_rd && (bus_addr == 4'd0);
      u_rise = m_s2 && !m_s3;
      m_pend = u_rise || (m_pend && !u_e);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ce_pin;
      if (u_e && m_en) m_flag = 1;
      else if (u_rd)   m_flag = 0;
      if (u_rd) m_en = 1;
      if (int'(mode_sel) != m_mode) begin
        m_mode = int'(mode_sel);
        m_cnt  = 0;
      end else begin
        m_cnt = (m_cnt + 1) % 1024;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops scoreboard items and compares the chip-enable pulse
  always @(negedge clk) begin
    if (rst_n && m_hold >= 2) begin
      if (bus_rd) begin
        if (sb_q.size() == 0) check(0, "R2 (no expected item)", int'(bus_rdata), -1);
        else begin
          item_t it;
          it = sb_q.pop_front();
          check(bus_rdata === it.exp, it.req, int'(bus_rdata), int'(it.exp));
        end
      end
      check(ce_reset_o === (m_pend && evt_now()), "R7 ce_reset_o timing",
            int'(ce_reset_o), int'(m_pend && evt_now()));
      if (ce_reset_o === 1'b1) ce_seen++;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // driver: one read cycle, expected value pushed to the scoreboard
  task automatic do_read(input logic [3:0] a, input string req);
    item_t it;
    bus_rd = 1'b1; bus_addr = a;
    it.exp = (a == 4'd0) ? {7'd0, m_flag} : 8'd0;
    it.req = req;
    sb_q.push_back(it);
    tick(1);
    bus_rd = 1'b0; bus_addr = 4'd0;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0; bus_addr = 4'd0; bus_wdata = 8'd0;
  endtask

  task automatic wait_event();
    while (!evt_now()) tick(1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; ce_pin = 0; mode_sel = 2'd0;
    bus_rd = 0; bus_wr = 0; bus_addr = 4'd0; bus_wdata = 8'd0;
    tick(4);
    // R4: outputs quiet in reset
    @(negedge clk);
    check(bus_rdata === 8'd0, "R4 rdata in reset", int'(bus_rdata), 0);
    check(ce_reset_o === 1'b0, "R4 ce_reset_o in reset", int'(ce_reset_o), 0);
    @(posedge clk); #1;
    rst_n = 1;
    tick(6);
    // R7: chip-enable rise before the flag is armed
    ce_pin = 1;
    tick(40);
    check(ce_seen == 1, "R7 pulse before arming", ce_seen, 1);
    // R4: events ignored so far, first read yields 0
    do_read(4'd0, "R4 first read");
    tick(20);
    do_read(4'd0, "R1 R3 flag after event");
    do_read(4'd0, "R2 read clears");
    tick(20);
    do_read(4'd5, "R5 other address");
    do_read(4'd0, "R5 flag kept after other address");
    // R6: writes leave the flag alone in both states
    do_write(4'd0, 8'hFF);
    do_write(4'd0, 8'h01);
    do_read(4'd0, "R6 write while clear");
    tick(20);
    do_write(4'd0, 8'h00);
    do_write(4'd3, 8'hAA);
    do_read(4'd0, "R6 write while set");
    // R9: read on the very set event
    do_read(4'd0, "R9 clear before tie");
    wait_event();
    do_read(4'd0, "R9 tie read returns old");
    do_read(4'd0, "R9 carry kept");
    // R10 and R1 across modes, with a second pin rise once armed
    ce_pin = 0;
    for (int md = 1; md < 4; md++) begin
      mode_sel = 2'(md);
      tick(2);
      do_read(4'd0, "R10 clear after mode switch");
      if (md == 2) ce_pin = 1;
      for (int k = 0; k < (3 * per(md)) / 13; k++) begin
        tick(12);
        do_read(4'd0, "R1 R10 polled interval");
      end
      // exact edge: read on the event cycle, then just after
      do_read(4'd0, "R1 clear before edge");
      wait_event();
      do_read(4'd0, "R1 event cycle");
      do_read(4'd0, "R1 set after edge");
    end
    check(ce_seen == 2, "R8 one pulse per rise", ce_seen, 2);
    tick(8);
    check(sb_q.size() == 0, "R2 scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule